// File: doc/BRIEF.md
# Frequency-Count Replacement State for One Cache Set

This block keeps the replacement bookkeeping for a single set of an N-way set-associative cache. Each way owns a saturating use counter and a one-bit recency guard. The cache controller tells the block when a way is hit (a touch) or when a new block is written into a way (a fill). A fill carries an insertion-policy select and a flag that says whether the block is a demand fill or a prefetch. Tag comparison and the data array stay in the controller. The controller also supplies the per-way valid bits and stored tags, so that the block can name a way to evict.

The victim output is combinational from the current state, the valid bits and the tags. An empty way is always taken first. Otherwise the least-used way wins, but the guarded (most recently claimed) way is skipped. Equal counts are resolved by the smaller stored tag. Counters and guard bits are also driven out, so the controller can inspect the state.

Top module: `freq_repl_set`

## Requirements
- R1: Synchronous reset (active high) clears every use counter to 0 and every guard bit to 0.
- R2: A touch (`cmd_op` = 2'b01) of way w sets guard bit w, clears every other guard bit, and adds 1 to counter w.
- R3: A fill (`cmd_op` = 2'b10) with `fill_guard` = 1 sets guard bit w and clears all other guard bits.
- R4: A fill with `fill_guard` = 0 clears guard bit w and leaves the guard bits of the other ways unchanged.
- R5: A fill loads counter w with 1 when `fill_prefetch` = 0, and with 0 when `fill_prefetch` = 1.
- R6: A use counter stops at its maximum value (2^CNT_W - 1, which is 7 by default) and does not wrap.
- R7: When any way is invalid, the victim is the lowest-numbered invalid way.
- R8: When all ways are valid, the victim is a way with the smallest use count among the ways whose guard bit is clear.
- R9: Among candidates with equal counts, the way with the smaller stored tag is the victim; if the tags are also equal, the lower way index wins.
- R10: When no valid way has a clear guard bit, as in a one-way set after a touch, the count and tag rule applies to all ways and ignores the guard bits.
- R11: `cmd_op` values 2'b00 and 2'b11 change no counter and no guard bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | 00 idle, 01 touch, 10 fill, 11 idle |
| cmd_way | input | WAY_W | Way addressed by the command |
| fill_guard | input | 1 | Fill policy: 1 sets the guard bit of the new way, 0 clears it |
| fill_prefetch | input | 1 | Fill is a prefetch (counter starts at 0) |
| way_valid | input | NUM_WAYS | Valid bit of each way |
| way_tags | input | NUM_WAYS*TAG_W | Stored tag of each way, way 0 in the low bits |
| victim_way | output | WAY_W | Way to evict |
| way_guard | output | NUM_WAYS | Guard bit of each way |
| way_count | output | NUM_WAYS*CNT_W | Use counter of each way, way 0 in the low bits |

## Verification
On every cycle, the assertions check the following: at most one guard bit is set, each command has its effect on the guard bits and on the counters, idle codes leave the state frozen, counters saturate, and the victim is never a guarded way or a valid way while an empty one exists. Only the bench scenarios can show that the chosen way is the right one by count and tag. That covers the ordering across long touch and fill sequences, a victim that moves when only a tag changes, and the fallback in a one-way set.

// File: rtl/freq_repl_pkg.sv
package freq_repl_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_TOUCH = 2'b01,
        OP_FILL  = 2'b10,
        OP_RSVD  = 2'b11
    } repl_op_e;

    typedef struct packed {
        logic touch;
        logic fill;
        logic guard_new;
        logic prefetch;
    } slot_cmd_t;

    function automatic slot_cmd_t decode_cmd(input logic [1:0] op,
                                             input logic       hit_this,
                                             input logic       guard_in,
                                             input logic       pf_in);
        slot_cmd_t c;
        c.touch     = hit_this && (op == OP_TOUCH);
        c.fill      = hit_this && (op == OP_FILL);
        c.guard_new = guard_in;
        c.prefetch  = pf_in;
        return c;
    endfunction

    function automatic logic claims_guard(input logic [1:0] op, input logic guard_in);
        return (op == OP_TOUCH) || ((op == OP_FILL) && guard_in);
    endfunction

endpackage

// File: rtl/freq_way_slot.sv
module freq_way_slot
    import freq_repl_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_cmd_t        cmd,
    input  logic             other_claim,
    output logic [CNT_W-1:0] cnt_q,
    output logic             guard_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            guard_q <= 1'b0;
        end else if (cmd.touch) begin
            guard_q <= 1'b1;
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end else if (cmd.fill) begin
            guard_q <= cmd.guard_new;
            cnt_q   <= cmd.prefetch ? '0 : CNT_W'(1);
        end else if (other_claim) begin
            guard_q <= 1'b0;
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd.touch && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

    assert_fill_start_R5: assert property (@(posedge clk) disable iff (rst)
        cmd.fill |=> (cnt_q == ($past(cmd.prefetch) ? '0 : CNT_W'(1))));

endmodule

// File: rtl/freq_victim_pick.sv
module freq_victim_pick #(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 8,
    parameter int CNT_W    = 3,
    parameter int WAY_W    = 2
) (
    input  logic [NUM_WAYS-1:0]       valid,
    input  logic [NUM_WAYS-1:0]       guard,
    input  logic [NUM_WAYS*CNT_W-1:0] cnts,
    input  logic [NUM_WAYS*TAG_W-1:0] tags,
    output logic [WAY_W-1:0]          victim
);
    logic [NUM_WAYS-1:0] eligible;
    logic                any_empty;
    logic [WAY_W-1:0]    empty_idx;
    logic [WAY_W-1:0]    best_idx;
    logic [CNT_W-1:0]    best_cnt;
    logic [TAG_W-1:0]    best_tag;
    logic                best_found;

    // lowest-numbered invalid way
    always_comb begin
        any_empty = 1'b0;
        empty_idx = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_empty = 1'b1;
                empty_idx = WAY_W'(i);
            end
        end
    end

    // unguarded ways, or all ways when none is unguarded
    always_comb begin
        eligible = ~guard;
        if (eligible == '0) eligible = '1;
    end

    // minimum count, then smaller tag; strict compare keeps lower index
    always_comb begin
        best_found = 1'b0;
        best_idx   = '0;
        best_cnt   = '0;
        best_tag   = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (eligible[i]) begin
                if (!best_found
                    || (cnts[i*CNT_W +: CNT_W] < best_cnt)
                    || ((cnts[i*CNT_W +: CNT_W] == best_cnt)
                        && (tags[i*TAG_W +: TAG_W] < best_tag))) begin
                    best_found = 1'b1;
                    best_idx   = WAY_W'(i);
                    best_cnt   = cnts[i*CNT_W +: CNT_W];
                    best_tag   = tags[i*TAG_W +: TAG_W];
                end
            end
        end
    end

    assign victim = any_empty ? empty_idx : best_idx;

endmodule

// File: rtl/freq_repl_set.sv
module freq_repl_set
    import freq_repl_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 8,
    parameter int CNT_W    = 3,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                cmd_op,
    input  logic [WAY_W-1:0]          cmd_way,
    input  logic                      fill_guard,
    input  logic                      fill_prefetch,
    input  logic [NUM_WAYS-1:0]       way_valid,
    input  logic [NUM_WAYS*TAG_W-1:0] way_tags,
    output logic [WAY_W-1:0]          victim_way,
    output logic [NUM_WAYS-1:0]       way_guard,
    output logic [NUM_WAYS*CNT_W-1:0] way_count
);
    logic claim;
    assign claim = claims_guard(cmd_op, fill_guard);

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_slot
        logic             hit_this;
        slot_cmd_t        scmd;
        logic [CNT_W-1:0] cnt_w;
        logic             grd_w;

        assign hit_this = (cmd_way == WAY_W'(g));
        assign scmd     = decode_cmd(cmd_op, hit_this, fill_guard, fill_prefetch);

        freq_way_slot #(.CNT_W(CNT_W)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .cmd        (scmd),
            .other_claim(claim && !hit_this),
            .cnt_q      (cnt_w),
            .guard_q    (grd_w)
        );

        assign way_count[g*CNT_W +: CNT_W] = cnt_w;
        assign way_guard[g]                = grd_w;
    end

    freq_victim_pick #(
        .NUM_WAYS(NUM_WAYS),
        .TAG_W   (TAG_W),
        .CNT_W   (CNT_W),
        .WAY_W   (WAY_W)
    ) u_pick (
        .valid (way_valid),
        .guard (way_guard),
        .cnts  (way_count),
        .tags  (way_tags),
        .victim(victim_way)
    );

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (way_guard == '0 && way_count == '0));

    assert_single_guard_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(way_guard));

    assert_touch_claim_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_TOUCH) |=> (way_guard == (NUM_WAYS'(1) << $past(cmd_way))));

    assert_guard_fill_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_FILL && fill_guard) |=> (way_guard == (NUM_WAYS'(1) << $past(cmd_way))));

    assert_open_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_FILL && !fill_guard) |=>
        ((way_guard & (NUM_WAYS'(1) << $past(cmd_way))) == '0) &&
        ((way_guard | (NUM_WAYS'(1) << $past(cmd_way))) ==
         ($past(way_guard) | (NUM_WAYS'(1) << $past(cmd_way)))));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == OP_IDLE || cmd_op == OP_RSVD) |=> ($stable(way_guard) && $stable(way_count)));

    assert_empty_first_R7: assert property (@(posedge clk) disable iff (rst)
        (way_valid != '1) |-> !way_valid[victim_way]);

    assert_skip_guarded_R8: assert property (@(posedge clk) disable iff (rst)
        ((way_valid == '1) && (way_guard != '1)) |-> !way_guard[victim_way]);

endmodule

// File: tb/tb_freq_repl_set.sv
module tb_freq_repl_set;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int TW = 8;
    localparam int CW = 3;

    typedef struct packed {
        logic [1:0] op;
        logic [1:0] way;
        logic       grd;
        logic       pf;
        logic [3:0] exp_guard;
        logic [2:0] exp_cnt;
        logic [1:0] exp_vic;
    } vec_t;

    // tags: w0=0x40 w1=0x10 w2=0x30 w3=0x20, all valid
    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 2'd0, 1'b1, 1'b0, 4'b0001, 3'd1, 2'd1},
        '{2'd2, 2'd1, 1'b1, 1'b1, 4'b0010, 3'd0, 2'd3},
        '{2'd1, 2'd3, 1'b0, 1'b0, 4'b1000, 3'd1, 2'd1},
        '{2'd1, 2'd1, 1'b0, 1'b0, 4'b0010, 3'd1, 2'd2},
        '{2'd2, 2'd2, 1'b0, 1'b0, 4'b0010, 3'd1, 2'd3},
        '{2'd1, 2'd3, 1'b0, 1'b0, 4'b1000, 3'd2, 2'd1},
        '{2'd2, 2'd3, 1'b0, 1'b1, 4'b0000, 3'd0, 2'd3},
        '{2'd1, 2'd0, 1'b0, 1'b0, 4'b0001, 3'd2, 2'd3},
        '{2'd2, 2'd1, 1'b0, 1'b0, 4'b0001, 3'd1, 2'd3},
        '{2'd0, 2'd0, 1'b0, 1'b0, 4'b0001, 3'd2, 2'd3},
        '{2'd3, 2'd2, 1'b0, 1'b0, 4'b0001, 3'd1, 2'd3},
        '{2'd1, 2'd3, 1'b0, 1'b0, 4'b1000, 3'd1, 2'd1},
        '{2'd1, 2'd2, 1'b0, 1'b0, 4'b0100, 3'd2, 2'd1},
        '{2'd2, 2'd2, 1'b0, 1'b0, 4'b0000, 3'd1, 2'd1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cmd_op = 2'd0;
    logic [1:0]    cmd_way = 2'd0;
    logic          fill_guard = 1'b0;
    logic          fill_prefetch = 1'b0;
    logic [NW-1:0] way_valid = '1;
    logic [NW*TW-1:0] way_tags = {8'h20, 8'h30, 8'h10, 8'h40};
    logic [1:0]    victim_way;
    logic [NW-1:0] way_guard;
    logic [NW*CW-1:0] way_count;

    logic       op1 = 1'b0;
    logic [1:0] cmd_op1;
    logic       victim1;
    logic       guard1;
    logic [CW-1:0] count1;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmd_op1 = op1 ? 2'b01 : 2'b00;

    freq_repl_set #(.NUM_WAYS(NW), .TAG_W(TW), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_way(cmd_way),
        .fill_guard(fill_guard), .fill_prefetch(fill_prefetch),
        .way_valid(way_valid), .way_tags(way_tags),
        .victim_way(victim_way), .way_guard(way_guard), .way_count(way_count)
    );

    freq_repl_set #(.NUM_WAYS(1), .TAG_W(TW), .CNT_W(CW)) dut_one (
        .clk(clk), .rst(rst), .cmd_op(cmd_op1), .cmd_way(1'b0),
        .fill_guard(1'b0), .fill_prefetch(1'b0),
        .way_valid(1'b1), .way_tags(8'h55),
        .victim_way(victim1), .way_guard(guard1), .way_count(count1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [1:0] w, input logic g, input logic pf);
        @(negedge clk);
        cmd_op = op; cmd_way = w; fill_guard = g; fill_prefetch = pf;
        @(posedge clk);
        @(negedge clk);
        cmd_op = 2'd0;
    endtask

    function automatic logic [2:0] cnt_of(input int w);
        return way_count[w*CW +: CW];
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 guard", 32'(way_guard), 32'h0);
        check("R1 count", 32'(way_count), 32'h0);
        check("R9 reset victim", 32'(victim_way), 32'd1);

        // R2 R3 R4 R5 R8 R9 R11 table walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].op, VEC[i].way, VEC[i].grd, VEC[i].pf);
            check($sformatf("R2/R3/R4/R11 guard step %0d", i), 32'(way_guard), 32'(VEC[i].exp_guard));
            check($sformatf("R2/R5/R11 count step %0d", i), 32'(cnt_of(int'(VEC[i].way))), 32'(VEC[i].exp_cnt));
            check($sformatf("R8/R9 victim step %0d", i), 32'(victim_way), 32'(VEC[i].exp_vic));
        end

        // R6 saturation: way0 count 2, nine touches
        for (int k = 0; k < 9; k++) drive(2'd1, 2'd0, 1'b0, 1'b0);
        check("R6 saturate", 32'(cnt_of(0)), 32'd7);
        drive(2'd1, 2'd0, 1'b0, 1'b0);
        check("R6 hold max", 32'(cnt_of(0)), 32'd7);
        check("R2 guard after touch", 32'(way_guard), 32'b0001);

        // R9 victim follows tag change alone (counts w1..w3 all 1)
        check("R9 victim before tag change", 32'(victim_way), 32'd1);
        @(negedge clk);
        way_tags[1*TW +: TW] = 8'h50;
        #1;
        check("R9 victim after tag change", 32'(victim_way), 32'd3);

        // R7 empty way preference
        way_valid = 4'b1010; #1;
        check("R7 lowest invalid", 32'(victim_way), 32'd0);
        way_valid = 4'b0111; #1;
        check("R7 only invalid", 32'(victim_way), 32'd3);
        way_valid = 4'b1011; #1;
        check("R7 invalid guarded-free", 32'(victim_way), 32'd2);
        way_valid = 4'b1111; #1;

        // R10 one-way fallback
        check("R10 one-way reset victim", 32'(victim1), 32'd0);
        @(negedge clk); op1 = 1'b1;
        @(posedge clk); @(negedge clk); op1 = 1'b0;
        check("R10 one-way guard set", 32'(guard1), 32'd1);
        check("R10 one-way victim", 32'(victim1), 32'd0);
        check("R2 one-way count", 32'(count1), 32'd1);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); @(negedge clk); rst = 1'b0;
        check("R1 guard after reset", 32'(way_guard), 32'h0);
        check("R1 count after reset", 32'(way_count), 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule